// File: doc/BRIEF.md
# Dual-Core Mailbox and Sleep Controller

This peripheral sits between two processor cores. It gives them a small shared flag word, a one-bit posting queue for each core, and a control register per core that can put that core to sleep. Each core has its own register port, so the port index serves as the core identity. Both cores can reach every register in the same clock cycle.

The flag word has three access points. A status view returns the current bits. A set view ORs in the ones of the written data. A clear view removes them. Software places its wake-in-progress, sleep-intent and stay-awake markers in this word at fixed per-core positions. A core posts to the other core's queue by writing to it. The posting flag is cleared only when the owning core reads its queue.

Writing a control register with bit 31 high halts that core through its sleep output. Writing zero, from either core, releases it. Reads return data one cycle after the request, together with a valid strobe.

Top module: `dual_core_mbox`

## Requirements
- R1: A read of offset 0x00 returns the six implemented flag bits in data bits 5:0. For core n, bit n is wake-in-progress, bit 2+n is sleep intent and bit 4+n is stay-awake. Data bits 31:6 read zero.
- R2: A write to offset 0x04 sets every flag bit whose data bit is one. A write to offset 0x08 clears every flag bit whose data bit is one. A clear with mask 0x3F empties the word.
- R3: When a set and a clear hit the same flag bit in one cycle, from the same or different ports, the bit ends up set.
- R4: Flag bits 31:6 ignore writes. Reads of offsets 0x04, 0x08 and of any unmapped offset return zero. Writes to unmapped offsets change nothing.
- R5: The queue of core 0 is at offset 0x10 and the queue of core 1 is at offset 0x20. A write to a queue from the other core sets its pending bit. A read returns that bit at data bit 29, with all other data bits zero.
- R6: A read of a queue by its owning core returns the value held before the read, then clears the bit. A read by the other core leaves the bit unchanged. A write by the owning core is ignored.
- R7: If the other core posts in the same cycle as the owner's clearing read, the read returns the old value and the bit stays set.
- R8: The control register of core n is at offset 0x40+4n, and either core may write it. A write loads data bit 31 as the sleep bit and ignores all other data bits. A read returns the sleep bit at data bit 31. Output core_sleep[n] follows the sleep bit from the cycle after the write.
- R9: If both ports write the same control register in one cycle and either writes bit 31 as zero, the core is released.
- R10: A read request produces rsp_valid and rsp_data on that port in the next cycle. The data reflects the state before any write in the request cycle. A write produces no rsp_valid.
- R11: After reset every register is zero, both sleep outputs are low and no rsp_valid is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_CORES | Access request, one bit per core port |
| req_write | input | NUM_CORES | 1 = write, 0 = read, per port |
| req_addr | input | NUM_CORES*ADDR_W | Byte offset per port, port p in slice p |
| req_wdata | input | NUM_CORES*32 | Write data per port |
| rsp_valid | output | NUM_CORES | Read data valid, one cycle after a read |
| rsp_data | output | NUM_CORES*32 | Read data per port |
| core_sleep | output | NUM_CORES | Halt line for each core, high while its sleep bit is set |

## Verification
Three pairs of actions can land in the same cycle. One core can set a flag bit while the other clears it. The owner can read its queue while the other core posts to it. Both cores can write one control register, one asking for sleep and the other for release. The bench provokes each pair on purpose, by driving both ports on the same clock edge. It then reads back through the normal ports to confirm that the set, the post and the release win. A behavioural model tracks every register and is compared on every clock during a long stretch of random dual-port traffic, where such collisions also occur by chance.

// File: rtl/mbox_pkg.sv
`timescale 1ns/1ps
package mbox_pkg;
    localparam int DATA_W         = 32;
    localparam int QUEUE_BIT      = 29;
    localparam int SLEEP_BIT      = 31;
    localparam int OFS_STAT       = 'h00;
    localparam int OFS_SET        = 'h04;
    localparam int OFS_CLR        = 'h08;
    localparam int OFS_QUEUE_BASE = 'h10;
    localparam int OFS_QUEUE_STEP = 'h10;
    localparam int OFS_CTL_BASE   = 'h40;
    localparam int OFS_CTL_STEP   = 'h04;
endpackage

// File: rtl/mbox_decode.sv
`timescale 1ns/1ps
module mbox_decode
    import mbox_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_CORES = 2
) (
    input  logic                 valid,
    input  logic                 write,
    input  logic [ADDR_W-1:0]    addr,
    output logic                 rd_stat,
    output logic                 wr_set,
    output logic                 wr_clr,
    output logic [NUM_CORES-1:0] rd_queue,
    output logic [NUM_CORES-1:0] wr_queue,
    output logic [NUM_CORES-1:0] rd_ctl,
    output logic [NUM_CORES-1:0] wr_ctl
);
    logic rd_en;
    logic wr_en;

    assign rd_en = valid & ~write;
    assign wr_en = valid &  write;

    always_comb begin
        rd_stat = rd_en && (addr == ADDR_W'(OFS_STAT));
        wr_set  = wr_en && (addr == ADDR_W'(OFS_SET));
        wr_clr  = wr_en && (addr == ADDR_W'(OFS_CLR));
        for (int n = 0; n < NUM_CORES; n++) begin
            rd_queue[n] = rd_en && (addr == ADDR_W'(OFS_QUEUE_BASE + n * OFS_QUEUE_STEP));
            wr_queue[n] = wr_en && (addr == ADDR_W'(OFS_QUEUE_BASE + n * OFS_QUEUE_STEP));
            rd_ctl[n]   = rd_en && (addr == ADDR_W'(OFS_CTL_BASE + n * OFS_CTL_STEP));
            wr_ctl[n]   = wr_en && (addr == ADDR_W'(OFS_CTL_BASE + n * OFS_CTL_STEP));
        end
    end
endmodule

// File: rtl/mbox_flags.sv
`timescale 1ns/1ps
module mbox_flags #(
    parameter int FLAG_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_mask,
    input  logic [FLAG_W-1:0] clr_mask,
    output logic [FLAG_W-1:0] flags_q
);
    typedef struct packed {
        logic [FLAG_W-1:0] bits;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bits = (st_q.bits & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_q = st_q.bits;

    // R3: a requested set always lands, even against a clear
    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_mask) |=> ((flags_q & $past(set_mask)) == $past(set_mask)));

    // R2: a clear without a competing set removes the bits
    a_r2_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_mask & ~set_mask)) |=> ((flags_q & $past(clr_mask & ~set_mask)) == '0));

    // R2: no write, no change
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_mask == '0) && (clr_mask == '0)) |=> $stable(flags_q));
endmodule

// File: rtl/mbox_queue.sv
`timescale 1ns/1ps
module mbox_queue (
    input  logic clk,
    input  logic rst_n,
    input  logic post,
    input  logic take,
    output logic pending_q
);
    typedef struct packed {
        logic pending;
    } queue_state_t;

    queue_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (post)      st_d.pending = 1'b1;
        else if (take) st_d.pending = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending_q = st_q.pending;

    // R6: owner read alone empties the queue
    a_r6_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !post) |=> !pending_q);

    // R7: a post is never lost, even against a clearing read
    a_r7_post_wins: assert property (@(posedge clk) disable iff (!rst_n)
        post |=> pending_q);

    // R6: untouched queue keeps its state
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!post && !take) |=> $stable(pending_q));
endmodule

// File: rtl/mbox_ctl.sv
`timescale 1ns/1ps
module mbox_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_any,
    input  logic wr_sleep,
    output logic sleep_q
);
    typedef struct packed {
        logic sleep;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_any) st_d.sleep = wr_sleep;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sleep_q = st_q.sleep;

    // R9: any write of zero releases the core
    a_r9_release_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && !wr_sleep) |=> !sleep_q);

    // R8: a sleep request takes effect next cycle
    a_r8_sleep_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && wr_sleep) |=> sleep_q);

    // R8: without a write the sleep bit holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_any |=> $stable(sleep_q));
endmodule

// File: rtl/dual_core_mbox.sv
`timescale 1ns/1ps
module dual_core_mbox
    import mbox_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int ADDR_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CORES-1:0]          req_valid,
    input  logic [NUM_CORES-1:0]          req_write,
    input  logic [NUM_CORES*ADDR_W-1:0]   req_addr,
    input  logic [NUM_CORES*DATA_W-1:0]   req_wdata,
    output logic [NUM_CORES-1:0]          rsp_valid,
    output logic [NUM_CORES*DATA_W-1:0]   rsp_data,
    output logic [NUM_CORES-1:0]          core_sleep
);
    localparam int FLAG_W = 3 * NUM_CORES;

    typedef struct packed {
        logic [NUM_CORES-1:0]        valid;
        logic [NUM_CORES*DATA_W-1:0] data;
    } rsp_t;

    logic                 dec_rd_stat [NUM_CORES];
    logic                 dec_wr_set  [NUM_CORES];
    logic                 dec_wr_clr  [NUM_CORES];
    logic [NUM_CORES-1:0] dec_rd_q    [NUM_CORES];
    logic [NUM_CORES-1:0] dec_wr_q    [NUM_CORES];
    logic [NUM_CORES-1:0] dec_rd_c    [NUM_CORES];
    logic [NUM_CORES-1:0] dec_wr_c    [NUM_CORES];

    logic [FLAG_W-1:0]    set_mask, clr_mask, flags_q;
    logic [NUM_CORES-1:0] q_post, q_take, q_pending;
    logic [NUM_CORES-1:0] c_wr_any, c_wr_sleep, c_sleep;
    logic                 unused_wdata;
    logic                 unused_own_post;

    rsp_t rsp_d, rsp_q;

    for (genvar p = 0; p < NUM_CORES; p++) begin : g_port
        mbox_decode #(
            .ADDR_W    (ADDR_W),
            .NUM_CORES (NUM_CORES)
        ) u_dec (
            .valid    (req_valid[p]),
            .write    (req_write[p]),
            .addr     (req_addr[p*ADDR_W +: ADDR_W]),
            .rd_stat  (dec_rd_stat[p]),
            .wr_set   (dec_wr_set[p]),
            .wr_clr   (dec_wr_clr[p]),
            .rd_queue (dec_rd_q[p]),
            .wr_queue (dec_wr_q[p]),
            .rd_ctl   (dec_rd_c[p]),
            .wr_ctl   (dec_wr_c[p])
        );
    end

    // merge the per-port requests into one update per register
    always_comb begin
        set_mask        = '0;
        clr_mask        = '0;
        q_post          = '0;
        q_take          = '0;
        c_wr_any        = '0;
        c_wr_sleep      = '1;
        unused_own_post = 1'b0;
        for (int p = 0; p < NUM_CORES; p++) begin
            if (dec_wr_set[p]) set_mask = set_mask | req_wdata[p*DATA_W +: FLAG_W];
            if (dec_wr_clr[p]) clr_mask = clr_mask | req_wdata[p*DATA_W +: FLAG_W];
            for (int n = 0; n < NUM_CORES; n++) begin
                if (p != n) begin
                    if (dec_wr_q[p][n]) q_post[n] = 1'b1;
                end else begin
                    if (dec_rd_q[p][n]) q_take[n] = 1'b1;
                    unused_own_post = unused_own_post ^ dec_wr_q[p][n];
                end
                if (dec_wr_c[p][n]) begin
                    c_wr_any[n]   = 1'b1;
                    c_wr_sleep[n] = c_wr_sleep[n] & req_wdata[p*DATA_W + SLEEP_BIT];
                end
            end
        end
    end

    assign unused_wdata = ^req_wdata;

    mbox_flags #(
        .FLAG_W (FLAG_W)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .flags_q  (flags_q)
    );

    for (genvar n = 0; n < NUM_CORES; n++) begin : g_core
        mbox_queue u_queue (
            .clk       (clk),
            .rst_n     (rst_n),
            .post      (q_post[n]),
            .take      (q_take[n]),
            .pending_q (q_pending[n])
        );

        mbox_ctl u_ctl (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_any   (c_wr_any[n]),
            .wr_sleep (c_wr_sleep[n]),
            .sleep_q  (c_sleep[n])
        );
    end

    // read path: state before this cycle's writes, registered once
    always_comb begin
        rsp_d = rsp_q;
        for (int p = 0; p < NUM_CORES; p++) begin
            rsp_d.valid[p]                = req_valid[p] & ~req_write[p];
            rsp_d.data[p*DATA_W +: DATA_W] = '0;
            if (dec_rd_stat[p]) rsp_d.data[p*DATA_W +: FLAG_W] = flags_q;
            for (int n = 0; n < NUM_CORES; n++) begin
                if (dec_rd_q[p][n]) rsp_d.data[p*DATA_W + QUEUE_BIT] = q_pending[n];
                if (dec_rd_c[p][n]) rsp_d.data[p*DATA_W + SLEEP_BIT] = c_sleep[n];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_data   = rsp_q.data;
    assign core_sleep = c_sleep;

    for (genvar p = 0; p < NUM_CORES; p++) begin : g_chk
        // R10: every read is answered in the next cycle
        a_r10_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[p] && !req_write[p]) |=> rsp_valid[p]);

        // R10: no strobe without a read
        a_r10_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            !(req_valid[p] && !req_write[p]) |=> !rsp_valid[p]);
    end
endmodule

// File: tb/sim_dual_core_mbox.sv
`timescale 1ns/1ps
module sim_dual_core_mbox;
    localparam int NC = 2;
    localparam int AW = 8;
    localparam int DW = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NC-1:0]     req_valid = '0;
    logic [NC-1:0]     req_write = '0;
    logic [NC*AW-1:0]  req_addr  = '0;
    logic [NC*DW-1:0]  req_wdata = '0;
    logic [NC-1:0]     rsp_valid;
    logic [NC*DW-1:0]  rsp_data;
    logic [NC-1:0]     core_sleep;

    dual_core_mbox #(.NUM_CORES(NC), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .core_sleep(core_sleep)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string cur_tag = "";

    // behavioural reference state
    int unsigned m_flag = 0;
    bit          m_q   [NC];
    bit          m_ctl [NC];
    bit          e_v   [NC];
    logic [31:0] e_d   [NC];
    string       e_tag [NC];

    // stimulus slots
    bit          s_v [NC];
    bit          s_w [NC];
    logic [7:0]  s_a [NC];
    logic [31:0] s_d [NC];

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=0x%08h exp=0x%08h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00:   return m_flag;
            8'h10:   return {2'b0, m_q[0], 29'b0};
            8'h20:   return {2'b0, m_q[1], 29'b0};
            8'h40:   return {m_ctl[0], 31'b0};
            8'h44:   return {m_ctl[1], 31'b0};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string addr_tag(input logic [7:0] a);
        case (a)
            8'h00:        return "R1";
            8'h10, 8'h20: return "R5";
            8'h40, 8'h44: return "R8";
            default:      return "R4";
        endcase
    endfunction

    task automatic put(input int p, input bit w, input logic [7:0] a, input logic [31:0] d);
        s_v[p] = 1'b1; s_w[p] = w; s_a[p] = a; s_d[p] = d;
    endtask

    // apply slots at a negedge, update model, compare at the next negedge
    task automatic cycle();
        int unsigned setm, clrm;
        for (int p = 0; p < NC; p++) begin
            req_valid[p]            = s_v[p];
            req_write[p]            = s_w[p];
            req_addr[p*AW +: AW]    = s_a[p];
            req_wdata[p*DW +: DW]   = s_d[p];
            e_v[p]   = s_v[p] && !s_w[p];
            e_d[p]   = model_read(s_a[p]);
            e_tag[p] = (cur_tag != "") ? cur_tag : addr_tag(s_a[p]);
        end
        setm = 0; clrm = 0;
        for (int p = 0; p < NC; p++) begin
            if (s_v[p] && s_w[p] && s_a[p] == 8'h04) setm |= s_d[p] & 32'h3F;
            if (s_v[p] && s_w[p] && s_a[p] == 8'h08) clrm |= s_d[p] & 32'h3F;
        end
        m_flag = (m_flag & ~clrm) | setm;
        for (int n = 0; n < NC; n++) begin
            bit post, take, anyw, val;
            logic [7:0] qa, ca;
            qa = 8'(16 * (n + 1));
            ca = 8'(64 + 4 * n);
            post = 0; take = 0; anyw = 0; val = 1;
            for (int p = 0; p < NC; p++) begin
                if (s_v[p] && s_w[p] && s_a[p] == qa && p != n) post = 1;
                if (s_v[p] && !s_w[p] && s_a[p] == qa && p == n) take = 1;
                if (s_v[p] && s_w[p] && s_a[p] == ca) begin
                    anyw = 1;
                    val  = val & s_d[p][31];
                end
            end
            if (post)      m_q[n] = 1'b1;
            else if (take) m_q[n] = 1'b0;
            if (anyw) m_ctl[n] = val;
        end
        @(negedge clk);
        for (int p = 0; p < NC; p++) begin
            chk(rsp_valid[p] == e_v[p], "R10", $sformatf("port%0d rsp_valid", p),
                32'(rsp_valid[p]), 32'(e_v[p]));
            if (e_v[p])
                chk(rsp_data[p*DW +: DW] == e_d[p], e_tag[p], $sformatf("port%0d rsp_data", p),
                    rsp_data[p*DW +: DW], e_d[p]);
            chk(core_sleep[p] == m_ctl[p], (cur_tag != "") ? cur_tag : "R8",
                $sformatf("core_sleep[%0d]", p), 32'(core_sleep[p]), 32'(m_ctl[p]));
        end
        for (int p = 0; p < NC; p++) begin
            s_v[p] = 0; s_w[p] = 0; s_a[p] = '0; s_d[p] = '0;
        end
    endtask

    task automatic rd(input int p, input logic [7:0] a);
        put(p, 1'b0, a, 32'h0); cycle();
    endtask

    task automatic wr(input int p, input logic [7:0] a, input logic [31:0] d);
        put(p, 1'b1, a, d); cycle();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R10 watchdog act=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] amap [12];
        amap = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h44,
                 8'h0C, 8'h14, 8'h3C, 8'h48, 8'h10};
        for (int p = 0; p < NC; p++) begin
            s_v[p] = 0; s_w[p] = 0; s_a[p] = '0; s_d[p] = '0;
            m_q[p] = 0; m_ctl[p] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state at the ports
        chk(rsp_valid == '0, "R11", "rsp_valid after reset", 32'(rsp_valid), 32'h0);
        chk(core_sleep == '0, "R11", "core_sleep after reset", 32'(core_sleep), 32'h0);
        cur_tag = "R11";
        rd(0, 8'h00); rd(1, 8'h10); rd(0, 8'h20); rd(1, 8'h40); rd(0, 8'h44);

        // R2: set and clear views, init clear 0x3F
        cur_tag = "R2";
        wr(0, 8'h04, 32'h15); rd(1, 8'h00);
        wr(1, 8'h08, 32'h05); rd(0, 8'h00);
        wr(0, 8'h08, 32'h3F); rd(0, 8'h00);

        // R4: upper flag bits ignore writes, write-only views and holes read zero
        cur_tag = "R4";
        wr(1, 8'h04, 32'hFFFF_FFFF); rd(0, 8'h00);
        rd(0, 8'h04); rd(1, 8'h08);
        wr(0, 8'h0C, 32'hFFFF_FFFF); wr(1, 8'h3C, 32'hFFFF_FFFF);
        rd(0, 8'h0C); rd(1, 8'h48); rd(0, 8'h00);
        wr(0, 8'h08, 32'h3F);

        // R3: set against clear on the same bits, same cycle, both ports
        cur_tag = "R3";
        put(0, 1'b1, 8'h04, 32'h0C); put(1, 1'b1, 8'h08, 32'h0F); cycle();
        rd(0, 8'h00);
        put(1, 1'b1, 8'h04, 32'h21); put(0, 1'b1, 8'h08, 32'h3F); cycle();
        rd(1, 8'h00);

        // R10: read sees state before a same-cycle write from the other port
        cur_tag = "R10";
        put(0, 1'b0, 8'h00, 32'h0); put(1, 1'b1, 8'h08, 32'h3F); cycle();
        rd(0, 8'h00);

        // R5: posting from the other core
        cur_tag = "R5";
        wr(1, 8'h10, 32'h0); rd(0, 8'h20); rd(1, 8'h10);
        wr(0, 8'h20, 32'h1234_5678); rd(0, 8'h20);

        // R6: owner read returns old value then clears; owner write ignored
        cur_tag = "R6";
        rd(1, 8'h10); rd(0, 8'h10); rd(0, 8'h10);
        wr(0, 8'h10, 32'hFFFF_FFFF); rd(1, 8'h10);
        rd(1, 8'h20); rd(1, 8'h20);

        // R7: post and clearing read in the same cycle
        cur_tag = "R7";
        wr(1, 8'h10, 32'h0);
        put(0, 1'b0, 8'h10, 32'h0); put(1, 1'b1, 8'h10, 32'h0); cycle();
        rd(0, 8'h10); rd(0, 8'h10);
        put(1, 1'b0, 8'h20, 32'h0); put(0, 1'b1, 8'h20, 32'h0); cycle();
        rd(1, 8'h20);

        // R8: sleep and release from either core
        cur_tag = "R8";
        wr(0, 8'h40, 32'h8000_0000); rd(1, 8'h40);
        wr(1, 8'h40, 32'h0); rd(0, 8'h40);
        wr(1, 8'h44, 32'hFFFF_FFFF); rd(0, 8'h44);
        wr(0, 8'h44, 32'h7FFF_FFFF); rd(1, 8'h44);

        // R9: conflicting control writes, release wins
        cur_tag = "R9";
        wr(1, 8'h44, 32'h8000_0000);
        put(0, 1'b1, 8'h44, 32'h8000_0000); put(1, 1'b1, 8'h44, 32'h0); cycle();
        rd(0, 8'h44);
        put(0, 1'b1, 8'h40, 32'h0); put(1, 1'b1, 8'h40, 32'h8000_0000); cycle();
        put(0, 1'b1, 8'h40, 32'h8000_0000); put(1, 1'b1, 8'h40, 32'h8000_0000); cycle();
        rd(1, 8'h40);
        put(0, 1'b1, 8'h40, 32'h0); put(1, 1'b1, 8'h40, 32'h8000_0000); cycle();
        rd(1, 8'h40);

        // random dual-port traffic against the model
        cur_tag = "";
        for (int i = 0; i < 3000; i++) begin
            for (int p = 0; p < NC; p++) begin
                if ($urandom_range(0, 3) != 0) begin
                    logic [31:0] d;
                    d = $urandom;
                    if ($urandom_range(0, 1) == 1) d[31] = 1'b0;
                    put(p, $urandom_range(0, 1) == 1, amap[$urandom_range(0, 11)], d);
                end
            end
            cycle();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule